// File: doc/BRIEF.md
# Feedback Divider Slide Sequencer

This block steers a running PLL from one feedback divider value (N) to another without a relock. It relies on ramp hardware that moves the loop gradually. A single-cycle start pulse comes with the wanted N. The sequencer first compares that value with the N field of the live coefficient word. If they already match, it reports completion at once and touches nothing.

Otherwise it runs a fixed handshake:
1. Raise the slowdown control and hold it for one microsecond.
2. Write the coefficient word, replacing only the N field.
3. Wait a further microsecond.
4. Enable the ramp and watch a synchronised ramp-done flag, for up to 500 microseconds.
5. Drop slowdown and ramp enable together and strobe a read-back of the slowdown control.
6. Pulse done, with a timeout flag that shows whether the ramp finished in time.

Microsecond timing comes from a prescaler set by a cycles-per-microsecond parameter. The two ramp step constants are loaded while reset is held, chosen by a reference-rate code. An unknown code raises a configuration error.

Top module: `ndiv_slide_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, slowdown, ramp_en, coef_wr_en, slow_rd, done, timeout and busy are all 0.
- R2: If target_n equals coef N (cur_coef[15:8]) when start is sampled in idle, done is 1 with timeout 0 in the next cycle, and no slowdown, ramp or write is ever asserted for that request.
- R3: When a slide starts, slowdown rises in the next cycle. It stays high for CYC_PER_US cycles before coef_wr_en pulses for exactly one cycle, with slowdown still high.
- R4: The written word carries target_n in bits [15:8], and the M field [7:0] and PL field [21:16] sampled from cur_coef at start.
- R5: ramp_en rises CYC_PER_US cycles after the write cycle, and it is only ever high while slowdown is high.
- R6: ramp_done_async passes through two flops. If it rises during ramp cycle d, ramp_en is high for exactly d+2 cycles, provided d+2 does not exceed the ramp limit.
- R7: If no synchronised ramp-done is seen, ramp_en stays high for exactly 500*CYC_PER_US cycles. timeout is then 1 in the done cycle; timeout is never high outside the done cycle.
- R8: Slowdown and ramp_en fall together in one cycle, with slow_rd high in that cycle. done follows in the next cycle, and the block is idle one cycle later.
- R9: A start pulse while busy is ignored: the running slide's timing and written N are unchanged.
- R10: While reset is low, step_a/step_b/cfg_err are loaded from ref_code as follows:

  | ref_code | Reference rate | step_a | step_b | cfg_err |
  |---|---|---|---|---|
  | 0 | 12 MHz | 0x2B | 0x0B | 0 |
  | 1 | 12.8 MHz | 0x2B | 0x0B | 0 |
  | 2 | 13 MHz | 0x2B | 0x0B | 0 |
  | 3 | 19.2 MHz | 0x12 | 0x08 | 0 |
  | 4 | 38.4 MHz | 0x04 | 0x05 | 0 |
  | 5–7 | none | 0 | 0 | 1 |

- R11: After reset is released, step_a, step_b and cfg_err hold their values whatever ref_code does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the step constants |
| ref_code | input | 3 | Reference-rate code |
| start | input | 1 | One-cycle request to slide |
| target_n | input | 8 | Wanted feedback divider |
| cur_coef | input | 22 | Live coefficient word {PL, N, M} |
| ramp_done_async | input | 1 | Ramp-finished flag from the ramp hardware, asynchronous |
| slowdown | output | 1 | Slowdown-mode control |
| ramp_en | output | 1 | Dynamic-ramp enable |
| coef_wr_en | output | 1 | Coefficient write strobe |
| coef_wr_data | output | 22 | Coefficient word to write |
| slow_rd | output | 1 | Read-back strobe of the slowdown control after exit |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ramp did not finish in time; valid with done |
| step_a | output | 8 | Ramp step constant A |
| step_b | output | 8 | Ramp step constant B |
| cfg_err | output | 1 | Reference code not supported |

## Verification
Timing is counted from the clock edge that samples start; with C = CYC_PER_US the expected timeline is:
- Cycle 1 shows done for an unchanged N, or slowdown for a real slide.
- The write falls in cycle C+1.
- ramp_en starts in cycle 2C+2 and lasts d+2 cycles, or 500*C cycles on timeout.
- The exit strobe and then done follow on the two next cycles.

The bench rebuilds this timeline from those counts and compares every control output on the falling edge of each cycle. It drives start and ramp_done_async on falling edges, so no result depends on ordering at the rising edge. The ramp limit is tested on both sides: a ramp that finishes on the last allowed cycle, one that finishes a cycle too late, and one that never finishes.

// File: rtl/ndsl_pkg.sv
// Shared types for the feedback divider slide sequencer.
// Assumes step constants are 8 bits and the reference code is 3 bits.
package ndsl_pkg;
    localparam int STEP_W = 8;
    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOW,
        ST_LOAD,
        ST_SETTLE,
        ST_RAMP,
        ST_EXIT,
        ST_FIN
    } slide_st_t;

    typedef struct packed {
        logic [STEP_W-1:0] a;
        logic [STEP_W-1:0] b;
        logic              bad;
    } step_cfg_t;

    // Map a reference-rate code to its ramp step pair.
    function automatic step_cfg_t step_lookup(input logic [CODE_W-1:0] code);
        step_cfg_t r;
        r = '{a: '0, b: '0, bad: 1'b1};
        case (code)
            3'd0, 3'd1, 3'd2: r = '{a: 8'h2B, b: 8'h0B, bad: 1'b0};
            3'd3:             r = '{a: 8'h12, b: 8'h08, bad: 1'b0};
            3'd4:             r = '{a: 8'h04, b: 8'h05, bad: 1'b0};
            default:          r = '{a: '0, b: '0, bad: 1'b1};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ndsl_sync.sv
// Multi-flop synchroniser for a single asynchronous level.
// Assumes the input is a slow level held for several cycles.
module ndsl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Each stage samples the previous one (first stage samples the input).
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else if (i == 0) chain_q[i] <= d_async;
                else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ndsl_step_cfg.sv
// Holds the ramp step constants, loaded from the reference code while reset is low.
// Assumes ref_code is stable during reset; it is ignored afterwards.
module ndsl_step_cfg
    import ndsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ref_code,
    output logic [STEP_W-1:0] step_a,
    output logic [STEP_W-1:0] step_b,
    output logic              cfg_err
);
    step_cfg_t cfg_q;

    // Load during reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= step_lookup(ref_code);
    end

    assign step_a  = cfg_q.a;
    assign step_b  = cfg_q.b;
    assign cfg_err = cfg_q.bad;

    p_steps_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(step_a) && $stable(step_b) && $stable(cfg_err)));
endmodule

// File: rtl/ndsl_us_timer.sv
// Microsecond timer: a cycle prescaler feeding a microsecond counter.
// Assumes restart is pulsed on every phase change; expire flags the last cycle of lim_us microseconds.
module ndsl_us_timer #(
    parameter int CYC_PER_US = 50,
    parameter int MAX_US     = 500,
    localparam int PRE_W     = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1,
    localparam int US_W      = $clog2(MAX_US + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [US_W-1:0] lim_us,
    output logic            expire
);
    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             tick;

    assign tick   = (pre_q == PRE_W'(CYC_PER_US - 1));
    assign expire = tick && (us_q == lim_us - US_W'(1));

    // Count cycles within a microsecond and whole microseconds since restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
            us_q  <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (tick) us_q <= us_q + US_W'(1);
        end
    end

    p_us_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_us != '0) |-> (us_q < lim_us));
endmodule

// File: rtl/ndiv_slide_seq.sv
// Feedback divider slide sequencer: slowdown, coefficient write, ramp enable,
// bounded wait for ramp-done, joint exit and read-back.
// Assumes coefficient layout {PL, N, M}, M in the low bits, and a one-cycle start pulse.
module ndiv_slide_seq
    import ndsl_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int DLY_US     = 1,
    parameter int TMO_US     = 500,
    parameter int M_W        = 8,
    parameter int N_W        = 8,
    parameter int P_W        = 6,
    localparam int COEF_W    = M_W + N_W + P_W,
    localparam int US_W      = $clog2(TMO_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ref_code,
    input  logic              start,
    input  logic [N_W-1:0]    target_n,
    input  logic [COEF_W-1:0] cur_coef,
    input  logic              ramp_done_async,
    output logic              slowdown,
    output logic              ramp_en,
    output logic              coef_wr_en,
    output logic [COEF_W-1:0] coef_wr_data,
    output logic              slow_rd,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [STEP_W-1:0] step_a,
    output logic [STEP_W-1:0] step_b,
    output logic              cfg_err
);
    slide_st_t      st_q, st_d;
    logic [N_W-1:0] tgt_q;
    logic [M_W-1:0] m_q;
    logic [P_W-1:0] pl_q;
    logic           tmo_q;
    logic           rdone_s;
    logic           expire;
    logic           tmr_restart;
    logic [US_W-1:0] lim_us;
    logic [N_W-1:0] cur_n;

    assign cur_n = cur_coef[M_W +: N_W];

    ndsl_step_cfg u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_code (ref_code),
        .step_a   (step_a),
        .step_b   (step_b),
        .cfg_err  (cfg_err)
    );

    ndsl_sync #(.STAGES(2)) u_rdone_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ramp_done_async),
        .q_sync  (rdone_s)
    );

    assign lim_us      = (st_q == ST_RAMP) ? US_W'(TMO_US) : US_W'(DLY_US);
    assign tmr_restart = (st_d != st_q) || (st_q == ST_IDLE);

    ndsl_us_timer #(.CYC_PER_US(CYC_PER_US), .MAX_US(TMO_US)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .lim_us  (lim_us),
        .expire  (expire)
    );

    // Next-state selection for the slide handshake.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:   if (start) st_d = (target_n == cur_n) ? ST_FIN : ST_SLOW;
            ST_SLOW:   if (expire) st_d = ST_LOAD;
            ST_LOAD:   st_d = ST_SETTLE;
            ST_SETTLE: if (expire) st_d = ST_RAMP;
            ST_RAMP:   if (rdone_s || expire) st_d = ST_EXIT;
            ST_EXIT:   st_d = ST_FIN;
            ST_FIN:    st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the request and the fields that must survive the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            m_q   <= '0;
            pl_q  <= '0;
        end else if (st_q == ST_IDLE && start) begin
            tgt_q <= target_n;
            m_q   <= cur_coef[0 +: M_W];
            pl_q  <= cur_coef[M_W+N_W +: P_W];
        end
    end

    // Timeout flag: cleared on a new request, set when the ramp window runs out.
    always_ff @(posedge clk) begin
        if (!rst_n)                         tmo_q <= 1'b0;
        else if (st_q == ST_IDLE && start)  tmo_q <= 1'b0;
        else if (st_q == ST_RAMP && expire && !rdone_s) tmo_q <= 1'b1;
    end

    assign slowdown     = (st_q == ST_SLOW) || (st_q == ST_LOAD) ||
                          (st_q == ST_SETTLE) || (st_q == ST_RAMP);
    assign ramp_en      = (st_q == ST_RAMP);
    assign coef_wr_en   = (st_q == ST_LOAD);
    assign coef_wr_data = {pl_q, tgt_q, m_q};
    assign slow_rd      = (st_q == ST_EXIT);
    assign done         = (st_q == ST_FIN);
    assign timeout      = (st_q == ST_FIN) && tmo_q;
    assign busy         = (st_q != ST_IDLE);

    p_eq_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && target_n == cur_n) |=> (done && !timeout && !slowdown));
    p_wr_in_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_wr_en |-> (slowdown && !ramp_en));
    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_wr_en |=> !coef_wr_en);
    p_ramp_in_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en |-> slowdown);
    p_tmo_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
    p_exit_joint_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slowdown) |-> ($past(ramp_en) && !ramp_en && slow_rd));
    p_done_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slow_rd |=> done);
endmodule

// File: tb/ndiv_slide_seq_test.sv
// Self-checking bench: a behavioural cycle timeline compared on every falling edge.
module ndiv_slide_seq_test;
    localparam int C    = 50;
    localparam int TMOC = 500 * C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ref_code = 3'd0;
    logic        start = 1'b0;
    logic [7:0]  target_n = 8'd0;
    logic [21:0] cur_coef = {6'd3, 8'd40, 8'd2};
    logic        ramp_done_async = 1'b0;
    logic        slowdown, ramp_en, coef_wr_en, slow_rd, busy, done, timeout, cfg_err;
    logic [21:0] coef_wr_data;
    logic [7:0]  step_a, step_b;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ndiv_slide_seq uut (
        .clk(clk), .rst_n(rst_n), .ref_code(ref_code), .start(start),
        .target_n(target_n), .cur_coef(cur_coef), .ramp_done_async(ramp_done_async),
        .slowdown(slowdown), .ramp_en(ramp_en), .coef_wr_en(coef_wr_en),
        .coef_wr_data(coef_wr_data), .slow_rd(slow_rd), .busy(busy), .done(done),
        .timeout(timeout), .step_a(step_a), .step_b(step_b), .cfg_err(cfg_err)
    );

    // Compare one cycle of control outputs with the expected timeline.
    task automatic chk(input bit es, input bit er, input bit ew, input logic [21:0] ed,
                       input bit erd, input bit edn, input bit eto, input bit eb,
                       input string tag);
        logic [6:0] act, exp;
        act = {slowdown, ramp_en, coef_wr_en, slow_rd, done, timeout, busy};
        exp = {es, er, ew, erd, edn, eto, eb};
        total++;
        if (act !== exp || (ew && coef_wr_data !== ed)) begin
            bad++;
            $display("FAIL %s t=%0t ctl act=%b exp=%b data act=%h exp=%h",
                     tag, $time, act, exp, coef_wr_data, ed);
        end
    endtask

    // Expected step constants for each reference code.
    task automatic chk_steps(input logic [2:0] code, input string tag);
        logic [16:0] e;
        case (code)
            3'd0, 3'd1, 3'd2: e = {8'h2B, 8'h0B, 1'b0};
            3'd3:             e = {8'h12, 8'h08, 1'b0};
            3'd4:             e = {8'h04, 8'h05, 1'b0};
            default:          e = {8'h00, 8'h00, 1'b1};
        endcase
        total++;
        if ({step_a, step_b, cfg_err} !== e) begin
            bad++;
            $display("FAIL %s code=%0d act=%h exp=%h", tag, code, {step_a, step_b, cfg_err}, e);
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        ref_code = code;
        repeat (3) @(negedge clk);
        chk(0, 0, 0, '0, 0, 0, 0, 0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(0, 0, 0, '0, 0, 0, 0, 0, "R1 after reset");
        chk_steps(code, "R10");
    endtask

    // Run one request; d = ramp cycle in which ramp-done rises (0 = never).
    task automatic slide(input logic [7:0] tgt, input int d, input bit poke);
        logic [21:0] word;
        int len;
        bit tmo;
        @(negedge clk);
        start = 1'b1;
        target_n = tgt;
        @(negedge clk);
        start = 1'b0;
        if (tgt == cur_coef[15:8]) begin
            chk(0, 0, 0, '0, 0, 1, 0, 1, "R2 done");
            @(negedge clk);
            chk(0, 0, 0, '0, 0, 0, 0, 0, "R2 idle");
            return;
        end
        word = {cur_coef[21:16], tgt, cur_coef[7:0]};
        for (int j = 1; j <= C; j++) begin
            chk(1, 0, 0, '0, 0, 0, 0, 1, "R3 slowdown");
            start = (poke && j == 3);
            if (poke && j == 3) target_n = tgt + 8'd7;
            @(negedge clk);
        end
        start = 1'b0;
        chk(1, 0, 1, word, 0, 0, 0, 1, "R4 write");
        cur_coef = word;
        @(negedge clk);
        for (int j = 1; j <= C; j++) begin
            chk(1, 0, 0, '0, 0, 0, 0, 1, "R5 settle");
            @(negedge clk);
        end
        tmo = !(d > 0 && d + 2 <= TMOC);
        len = tmo ? TMOC : d + 2;
        for (int r = 1; r <= len; r++) begin
            chk(1, 1, 0, '0, 0, 0, 0, 1, tmo ? "R7 ramp" : "R6 ramp");
            if (d > 0 && r >= d) ramp_done_async = 1'b1;
            @(negedge clk);
        end
        chk(0, 0, 0, '0, 1, 0, 0, 1, "R8 exit");
        ramp_done_async = 1'b0;
        @(negedge clk);
        chk(0, 0, 0, '0, 0, 1, tmo, 1, "R7 done");
        @(negedge clk);
        chk(0, 0, 0, '0, 0, 0, 0, 0, "R8 idle");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(3'd0);
        do_reset(3'd1);
        do_reset(3'd2);
        do_reset(3'd5);
        do_reset(3'd7);
        do_reset(3'd3);
        ref_code = 3'd4;
        repeat (5) @(negedge clk);
        chk_steps(3'd3, "R11 hold");
        do_reset(3'd4);
        ref_code = 3'd6;
        repeat (3) @(negedge clk);
        chk_steps(3'd4, "R11 hold");

        slide(8'd40, 0, 0);            // unchanged N
        slide(8'd60, 5, 1);            // normal, start poked while busy (R9)
        slide(8'd30, 1, 0);            // earliest ramp-done
        slide(8'd30, 0, 0);            // unchanged again after write
        slide(8'd90, TMOC - 2, 0);     // done on the last allowed cycle
        slide(8'd100, TMOC - 1, 0);    // one cycle too late: timeout
        slide(8'd110, 0, 0);           // ramp never finishes: timeout
        slide(8'd120, 3, 0);           // recovery after timeout

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule